// File: doc/BRIEF.md
# Stream Prefetch Buffer Pool

This block holds lines fetched ahead of the processor for streams that a detector has already found. It is a pool of small FIFOs split into two classes. Read-class buffers carry ordinary prefetched lines. Write-class buffers carry lines requested with exclusive ownership. The stream detector binds a stream to a buffer of the right class by giving its first and last line address and saying whether the stream is new in this epoch or recognised from an earlier one. The pool then emits line requests for that buffer and the anticipation engine fills them back in order. Processor lookups are served from the oldest line of a buffer, and each line consumed frees room for one more request.

How far ahead a buffer runs depends on where its stream came from. A stream first seen in this epoch is fetched cautiously, two lines ahead. A stream recognised from an earlier epoch is fetched up to the full FIFO depth, and never past its last line. A barrier drops every buffer at once.

Top module: `spbp_pool`

## Requirements
- R1: After reset no request is issued (`reqValid` stays 0) and every lookup answers with `missValid`.
- R2: `allocId` shows, in the same cycle, the buffer that an allocation of the class chosen by `allocWrite` takes. Buffers `0..NUM_RD-1` form the read class and `NUM_RD..NUM_RD+NUM_WR-1` form the write class. The lowest-index free buffer of the class is chosen first. If none is free, the least recently used buffer of the class is chosen. Both an allocation and a hit count as a use.
- R3: A buffer bound with `allocRecog=0` never has more than 2 lines outstanding, counting lines that are requested but not yet consumed by a hit.
- R4: A buffer bound with `allocRecog=1` keeps up to `DEPTH` lines outstanding.
- R5: No request address is greater than the stream's last line (`allocTail`, inclusive). Requests start at `allocHead` and go up by one per accepted request.
- R6: `reqExcl` is 1 for requests from write-class buffers and 0 for requests from read-class buffers.
- R7: A lookup hits when three things hold: its `lookupWrite` matches the buffer class, a filled line is waiting, and its address equals that buffer's oldest unconsumed line. On a hit, `hitValid` and `hitData` appear the next cycle, the line is removed, and one more request may follow. A lookup of any other line of the FIFO misses.
- R8: A lookup that hits nothing raises `missValid` the next cycle and leaves every buffer unchanged.
- R9: `barrier` invalidates every buffer and drops its lines. From the next cycle no request is issued and earlier lines miss.
- R10: When several buffers may issue, the lowest index is presented first. A request is taken when `reqValid` and `reqReady` are both 1.
- R11: Fills for a buffer are returned by hits in the order they arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| barrier | input | 1 | Epoch barrier; flushes every buffer |
| allocValid | input | 1 | Bind a stream to buffer `allocId` |
| allocWrite | input | 1 | Class for allocation: 1 write, 0 read |
| allocRecog | input | 1 | Stream recognised from an earlier epoch |
| allocHead | input | ADDR_W | First line to prefetch |
| allocTail | input | ADDR_W | Last line of the stream (inclusive) |
| allocId | output | BUF_W | Buffer the allocation takes |
| reqValid | output | 1 | A line request is presented |
| reqReady | input | 1 | Engine accepts the request |
| reqAddr | output | ADDR_W | Line address requested |
| reqExcl | output | 1 | Request in exclusive mode |
| reqBuf | output | BUF_W | Buffer the line is for |
| fillValid | input | 1 | Fill data arrives |
| fillBuf | input | BUF_W | Buffer being filled |
| fillData | input | DATA_W | Line payload |
| lookupValid | input | 1 | Processor lookup |
| lookupWrite | input | 1 | Lookup class: 1 write, 0 read |
| lookupAddr | input | ADDR_W | Line address looked up |
| hitValid | output | 1 | Previous lookup hit |
| missValid | output | 1 | Previous lookup missed |
| hitData | output | DATA_W | Line payload of the hit |

## Verification
`allocId` is combinational and is read within the cycle in which the allocation is driven. The first request of a buffer appears in the cycle after the allocating edge. A lookup result appears in the cycle after its edge, and the extra request that a hit allows appears in that same cycle. A barrier acts on the edge where it is sampled. The bench drives inputs on the falling edge and samples everything 1 ns before the next rising edge. A monitor pops expected requests and expected lookup results from two queues at that point. Any output that arrives with no matching queued item, or with different values, is reported.

// File: rtl/spbp_pkg.sv
package spbp_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic flushAll;
    logic clrEn;
    logic fillEn;
    logic popEn;
  } dpStrobe_t;

  function automatic int unsigned minU(input int unsigned a, input int unsigned b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/spbp_ctrl.sv
module spbp_ctrl
  import spbp_pkg::*;
#(
  parameter int unsigned NUM_RD     = 16,
  parameter int unsigned NUM_WR     = 16,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned CAUTIOUS   = 2,
  parameter int unsigned AGGR_DEPTH = 8,
  parameter int unsigned BUF_W      = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              barrier,
  input  logic              allocValid,
  input  logic              allocWrite,
  input  logic              allocRecog,
  input  logic [ADDR_W-1:0] allocHead,
  input  logic [ADDR_W-1:0] allocTail,
  output logic [BUF_W-1:0]  allocId,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqExcl,
  output logic [BUF_W-1:0]  reqBuf,
  input  logic              fillValid,
  input  logic [BUF_W-1:0]  fillBuf,
  input  logic              lookupValid,
  input  logic              lookupWrite,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hitValid,
  output logic              missValid,
  output dpStrobe_t         strb,
  output logic [BUF_W-1:0]  clrIdx,
  output logic [BUF_W-1:0]  popIdx
);

  localparam int unsigned NUM_BUF  = NUM_RD + NUM_WR;
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1);
  localparam int unsigned MAXC     = (NUM_RD > NUM_WR) ? NUM_RD : NUM_WR;
  localparam int unsigned RANK_W   = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam int unsigned AGGR_LIM = minU(AGGR_DEPTH, DEPTH);
  localparam int unsigned CAUT_LIM = minU(CAUTIOUS, DEPTH);

  logic [NUM_BUF-1:0] bufValid, bufRecog;
  logic [ADDR_W-1:0]  popAddr  [NUM_BUF];
  logic [ADDR_W-1:0]  nextAddr [NUM_BUF];
  logic [ADDR_W-1:0]  tailAddr [NUM_BUF];
  logic [CNT_W-1:0]   fillCnt  [NUM_BUF];
  logic [RANK_W-1:0]  rank     [NUM_BUF];

  logic [BUF_W-1:0]   victim, hitIdx, issueIdx, touchIdx;
  logic               hitFound, doHit, doIssue, fillOk, touchEn;
  logic [NUM_BUF-1:0] eligible;

  // ---------------- victim choice (free first, then LRU) ----------------
  always_comb begin
    logic freeFound;
    freeFound = 1'b0;
    victim    = '0;
    for (int i = 0; i < int'(NUM_BUF); i++) begin
      if (((i >= int'(NUM_RD)) == allocWrite) && !bufValid[i] && !freeFound) begin
        victim    = BUF_W'(i);
        freeFound = 1'b1;
      end
    end
    if (!freeFound) begin
      for (int i = 0; i < int'(NUM_BUF); i++) begin
        if ((i >= int'(NUM_RD)) == allocWrite) begin
          if (rank[i] == RANK_W'((allocWrite ? NUM_WR : NUM_RD) - 1)) victim = BUF_W'(i);
        end
      end
    end
  end
  assign allocId = victim;

  // ---------------- lookup match on FIFO heads ----------------
  always_comb begin
    hitFound = 1'b0;
    hitIdx   = '0;
    for (int i = 0; i < int'(NUM_BUF); i++) begin
      if (bufValid[i] && ((i >= int'(NUM_RD)) == lookupWrite) && (fillCnt[i] != '0) &&
          (popAddr[i] == lookupAddr) && !hitFound) begin
        hitFound = 1'b1;
        hitIdx   = BUF_W'(i);
      end
    end
  end
  assign doHit = lookupValid && hitFound && !barrier && !(allocValid && victim == hitIdx);

  // ---------------- request issue ----------------
  always_comb begin
    for (int i = 0; i < int'(NUM_BUF); i++) begin
      logic [ADDR_W-1:0] inFlight;
      logic [ADDR_W-1:0] lim;
      inFlight    = nextAddr[i] - popAddr[i];
      lim         = bufRecog[i] ? ADDR_W'(AGGR_LIM) : ADDR_W'(CAUT_LIM);
      eligible[i] = bufValid[i] && (inFlight < lim) && (nextAddr[i] <= tailAddr[i]) &&
                    !barrier && !(allocValid && victim == BUF_W'(i));
    end
  end

  always_comb begin
    logic got;
    got      = 1'b0;
    issueIdx = '0;
    for (int i = 0; i < int'(NUM_BUF); i++) begin
      if (eligible[i] && !got) begin
        issueIdx = BUF_W'(i);
        got      = 1'b1;
      end
    end
  end

  assign reqValid = |eligible;
  assign reqAddr  = nextAddr[issueIdx];
  assign reqExcl  = (issueIdx >= BUF_W'(NUM_RD));
  assign reqBuf   = issueIdx;
  assign doIssue  = reqValid && reqReady;

  // ---------------- fill acceptance ----------------
  assign fillOk = fillValid && bufValid[fillBuf] && (fillCnt[fillBuf] != CNT_W'(DEPTH)) &&
                  !barrier && !(allocValid && victim == fillBuf);

  // ---------------- LRU touch ----------------
  assign touchEn  = !barrier && (allocValid || doHit);
  assign touchIdx = allocValid ? victim : hitIdx;

  // ---------------- strobes to datapath ----------------
  assign strb.flushAll = barrier;
  assign strb.clrEn    = allocValid && !barrier;
  assign strb.fillEn   = fillOk;
  assign strb.popEn    = doHit;
  assign clrIdx        = victim;
  assign popIdx        = hitIdx;

  // ---------------- state ----------------
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid  <= '0;
      bufRecog  <= '0;
      hitValid  <= 1'b0;
      missValid <= 1'b0;
      for (int i = 0; i < int'(NUM_BUF); i++) begin
        popAddr[i]  <= '0;
        nextAddr[i] <= '0;
        tailAddr[i] <= '0;
        fillCnt[i]  <= '0;
        rank[i]     <= (i < int'(NUM_RD)) ? RANK_W'(i) : RANK_W'(i - int'(NUM_RD));
      end
    end else begin
      hitValid  <= doHit;
      missValid <= lookupValid && !doHit;
      if (barrier) begin
        bufValid <= '0;
        for (int i = 0; i < int'(NUM_BUF); i++) fillCnt[i] <= '0;
      end else begin
        for (int i = 0; i < int'(NUM_BUF); i++) begin
          if (allocValid && victim == BUF_W'(i)) begin
            bufValid[i] <= 1'b1;
            bufRecog[i] <= allocRecog;
            popAddr[i]  <= allocHead;
            nextAddr[i] <= allocHead;
            tailAddr[i] <= allocTail;
            fillCnt[i]  <= '0;
          end else begin
            if (doIssue && issueIdx == BUF_W'(i)) nextAddr[i] <= nextAddr[i] + 1'b1;
            if (doHit && hitIdx == BUF_W'(i)) popAddr[i] <= popAddr[i] + 1'b1;
            fillCnt[i] <= fillCnt[i]
                          + CNT_W'(fillOk && fillBuf == BUF_W'(i))
                          - CNT_W'(doHit && hitIdx == BUF_W'(i));
          end
          if (touchEn) begin
            if (touchIdx == BUF_W'(i)) begin
              rank[i] <= '0;
            end else if (((i >= int'(NUM_RD)) == (touchIdx >= BUF_W'(NUM_RD))) &&
                         (rank[i] < rank[touchIdx])) begin
              rank[i] <= rank[i] + 1'b1;
            end
          end
        end
      end
    end
  end

  // ---------------- assertions ----------------
  for (genvar g = 0; g < int'(NUM_BUF); g++) begin : gChk
    assert_cautious_window_R3: assert property (@(posedge clk) disable iff (!rstN)
      (bufValid[g] && !bufRecog[g]) |-> ((nextAddr[g] - popAddr[g]) <= ADDR_W'(CAUT_LIM)));
    assert_aggressive_window_R4: assert property (@(posedge clk) disable iff (!rstN)
      bufValid[g] |-> ((nextAddr[g] - popAddr[g]) <= ADDR_W'(AGGR_LIM)));
    assert_fifo_bound_R11: assert property (@(posedge clk) disable iff (!rstN)
      fillCnt[g] <= CNT_W'(DEPTH));
  end

  assert_req_tail_R5: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqAddr <= tailAddr[reqBuf]));

  assert_flush_all_R9: assert property (@(posedge clk) disable iff (!rstN)
    barrier |=> (bufValid == '0));

  assert_miss_keeps_R8: assert property (@(posedge clk) disable iff (!rstN)
    (lookupValid && !doHit && !barrier && !allocValid && !doIssue && !fillOk)
      |=> ($stable(bufValid) && $stable(fillCnt[0])));

endmodule

// File: rtl/spbp_data.sv
module spbp_data
  import spbp_pkg::*;
#(
  parameter int unsigned NUM_BUF = 32,
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned DATA_W  = 64,
  parameter int unsigned BUF_W   = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  input  logic [BUF_W-1:0]  clrIdx,
  input  logic [BUF_W-1:0]  fillIdx,
  input  logic [DATA_W-1:0] fillData,
  input  logic [BUF_W-1:0]  popIdx,
  output logic [DATA_W-1:0] hitData
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [NUM_BUF][DEPTH];
  logic [PTR_W-1:0]  wrPtr [NUM_BUF];
  logic [PTR_W-1:0]  rdPtr [NUM_BUF];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < int'(NUM_BUF); i++) begin
        wrPtr[i] <= '0;
        rdPtr[i] <= '0;
      end
    end else if (strb.flushAll) begin
      for (int i = 0; i < int'(NUM_BUF); i++) begin
        wrPtr[i] <= '0;
        rdPtr[i] <= '0;
      end
    end else begin
      for (int i = 0; i < int'(NUM_BUF); i++) begin
        if (strb.clrEn && clrIdx == BUF_W'(i)) begin
          wrPtr[i] <= '0;
          rdPtr[i] <= '0;
        end else begin
          if (strb.fillEn && fillIdx == BUF_W'(i)) wrPtr[i] <= bump(wrPtr[i]);
          if (strb.popEn && popIdx == BUF_W'(i))   rdPtr[i] <= bump(rdPtr[i]);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strb.fillEn) mem[fillIdx][wrPtr[fillIdx]] <= fillData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           hitData <= '0;
    else if (strb.popEn) hitData <= mem[popIdx][rdPtr[popIdx]];
  end

  assert_no_fill_on_flush_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.flushAll |-> !(strb.fillEn || strb.popEn));

endmodule

// File: rtl/spbp_pool.sv
module spbp_pool
  import spbp_pkg::*;
#(
  parameter int unsigned NUM_RD     = 16,
  parameter int unsigned NUM_WR     = 16,
  parameter int unsigned DEPTH      = 8,
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned DATA_W     = 64,
  parameter int unsigned CAUTIOUS   = 2,
  parameter int unsigned AGGR_DEPTH = 8,
  localparam int unsigned BUF_W     = $clog2(NUM_RD + NUM_WR)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              barrier,
  input  logic              allocValid,
  input  logic              allocWrite,
  input  logic              allocRecog,
  input  logic [ADDR_W-1:0] allocHead,
  input  logic [ADDR_W-1:0] allocTail,
  output logic [BUF_W-1:0]  allocId,
  output logic              reqValid,
  input  logic              reqReady,
  output logic [ADDR_W-1:0] reqAddr,
  output logic              reqExcl,
  output logic [BUF_W-1:0]  reqBuf,
  input  logic              fillValid,
  input  logic [BUF_W-1:0]  fillBuf,
  input  logic [DATA_W-1:0] fillData,
  input  logic              lookupValid,
  input  logic              lookupWrite,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hitValid,
  output logic              missValid,
  output logic [DATA_W-1:0] hitData
);

  dpStrobe_t        strb;
  logic [BUF_W-1:0] clrIdx, popIdx;

  spbp_ctrl #(
    .NUM_RD(NUM_RD), .NUM_WR(NUM_WR), .DEPTH(DEPTH), .ADDR_W(ADDR_W),
    .CAUTIOUS(CAUTIOUS), .AGGR_DEPTH(AGGR_DEPTH), .BUF_W(BUF_W)
  ) ctrl (
    .clk(clk), .rstN(rstN), .barrier(barrier),
    .allocValid(allocValid), .allocWrite(allocWrite), .allocRecog(allocRecog),
    .allocHead(allocHead), .allocTail(allocTail), .allocId(allocId),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqExcl(reqExcl), .reqBuf(reqBuf),
    .fillValid(fillValid), .fillBuf(fillBuf),
    .lookupValid(lookupValid), .lookupWrite(lookupWrite), .lookupAddr(lookupAddr),
    .hitValid(hitValid), .missValid(missValid),
    .strb(strb), .clrIdx(clrIdx), .popIdx(popIdx)
  );

  spbp_data #(
    .NUM_BUF(NUM_RD + NUM_WR), .DEPTH(DEPTH), .DATA_W(DATA_W), .BUF_W(BUF_W)
  ) data (
    .clk(clk), .rstN(rstN), .strb(strb), .clrIdx(clrIdx),
    .fillIdx(fillBuf), .fillData(fillData), .popIdx(popIdx), .hitData(hitData)
  );

  assert_excl_by_class_R6: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqExcl == (reqBuf >= BUF_W'(NUM_RD))));

  assert_lookup_answer_R7: assert property (@(posedge clk) disable iff (!rstN)
    lookupValid |=> (hitValid != missValid));

  assert_no_stray_answer_R8: assert property (@(posedge clk) disable iff (!rstN)
    !lookupValid |=> !(hitValid || missValid));

  assert_quiet_after_barrier_R9: assert property (@(posedge clk) disable iff (!rstN)
    (barrier && !allocValid) |=> !reqValid);

endmodule

// File: tb/spbp_pool_test.sv
module spbp_pool_test;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam int BW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic barrier = 1'b0;
  logic allocValid = 1'b0, allocWrite = 1'b0, allocRecog = 1'b0;
  logic [AW-1:0] allocHead = '0, allocTail = '0;
  logic [BW-1:0] allocId;
  logic reqValid, reqReady = 1'b1, reqExcl;
  logic [AW-1:0] reqAddr;
  logic [BW-1:0] reqBuf;
  logic fillValid = 1'b0;
  logic [BW-1:0] fillBuf = '0;
  logic [DW-1:0] fillData = '0;
  logic lookupValid = 1'b0, lookupWrite = 1'b0;
  logic [AW-1:0] lookupAddr = '0;
  logic hitValid, missValid;
  logic [DW-1:0] hitData;

  spbp_pool #(.NUM_RD(2), .NUM_WR(2), .DEPTH(4), .ADDR_W(AW), .DATA_W(DW),
              .CAUTIOUS(2), .AGGR_DEPTH(4)) uut (.*);

  always #10 clk = ~clk;

  typedef struct { logic [AW-1:0] addr; logic excl; logic [BW-1:0] bufId; string tag; } reqItem_t;
  typedef struct { logic hit; logic [DW-1:0] data; string tag; } lookItem_t;
  reqItem_t  expReqQ[$];
  lookItem_t expLookQ[$];

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  // monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #9;
      if (rstN) begin
        if (reqValid && reqReady) begin
          if (expReqQ.size() == 0) chk(0, "R3", "unexpected request addr", reqAddr, 0);
          else begin
            reqItem_t e;
            e = expReqQ.pop_front();
            chk(reqAddr == e.addr, e.tag, "request address", reqAddr, e.addr);
            chk(reqExcl == e.excl, e.tag, "request exclusive", reqExcl, e.excl);
            chk(reqBuf == e.bufId, e.tag, "request buffer", reqBuf, e.bufId);
          end
        end
        if (hitValid || missValid) begin
          if (expLookQ.size() == 0) chk(0, "R8", "unexpected lookup answer", hitValid, 0);
          else begin
            lookItem_t l;
            l = expLookQ.pop_front();
            chk(hitValid == l.hit, l.tag, "hit flag", hitValid, l.hit);
            chk(missValid == !l.hit, l.tag, "miss flag", missValid, !l.hit);
            if (l.hit) chk(hitData == l.data, l.tag, "hit data", hitData, l.data);
          end
        end
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expReq(input logic [AW-1:0] a, input logic x, input logic [BW-1:0] b, input string tag);
    reqItem_t e;
    e.addr = a; e.excl = x; e.bufId = b; e.tag = tag;
    expReqQ.push_back(e);
  endtask

  task automatic doAlloc(input logic wr, input logic rec, input logic [AW-1:0] h,
                         input logic [AW-1:0] t, input int expId, input string tag);
    @(negedge clk);
    allocValid = 1'b1; allocWrite = wr; allocRecog = rec; allocHead = h; allocTail = t;
    #5 chk(allocId == BW'(expId), tag, "allocation id", allocId, expId);
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic doFill(input logic [BW-1:0] b, input logic [DW-1:0] d);
    @(negedge clk);
    fillValid = 1'b1; fillBuf = b; fillData = d;
    @(negedge clk);
    fillValid = 1'b0;
  endtask

  task automatic doLookup(input logic wr, input logic [AW-1:0] a, input logic hit,
                          input logic [DW-1:0] d, input string tag);
    lookItem_t l;
    l.hit = hit; l.data = d; l.tag = tag;
    expLookQ.push_back(l);
    @(negedge clk);
    lookupValid = 1'b1; lookupWrite = wr; lookupAddr = a;
    @(negedge clk);
    lookupValid = 1'b0;
  endtask

  task automatic peekId(input logic wr, input int expId, input string tag);
    @(negedge clk);
    allocWrite = wr;
    #5 chk(allocId == BW'(expId), tag, "idle allocation id", allocId, expId);
  endtask

  initial begin
    #(20 * 100000);
    chk(0, "R1", "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    @(negedge clk);
    #5 chk(reqValid == 1'b0, "R1", "request after reset", reqValid, 0);
    doLookup(0, 16'h0100, 0, 0, "R1");

    // cautious read stream in buffer 0
    expReq(16'h0100, 0, 0, "R3");
    expReq(16'h0101, 0, 0, "R3");
    doAlloc(0, 0, 16'h0100, 16'h010F, 0, "R2");
    cyc(6);
    #5 chk(reqValid == 1'b0, "R3", "cautious window closed", reqValid, 0);

    doFill(0, 16'hA100);
    doFill(0, 16'hA101);
    doLookup(0, 16'h0101, 0, 0, "R7");           // not the head
    expReq(16'h0102, 0, 0, "R7");
    doLookup(0, 16'h0100, 1, 16'hA100, "R8");    // head untouched by the miss
    cyc(3);
    doLookup(0, 16'h0100, 0, 0, "R7");           // already consumed
    expReq(16'h0103, 0, 0, "R7");
    doLookup(0, 16'h0101, 1, 16'hA101, "R11");
    cyc(3);

    // recognised write stream, short tail, buffer 2
    expReq(16'h0200, 1, 2, "R6");
    expReq(16'h0201, 1, 2, "R4");
    expReq(16'h0202, 1, 2, "R5");
    doAlloc(1, 1, 16'h0200, 16'h0202, 2, "R2");
    cyc(8);
    #5 chk(reqValid == 1'b0, "R5", "stop at tail", reqValid, 0);

    // recognised read stream, long tail, buffer 1
    expReq(16'h0300, 0, 1, "R4");
    expReq(16'h0301, 0, 1, "R4");
    expReq(16'h0302, 0, 1, "R4");
    expReq(16'h0303, 0, 1, "R4");
    doAlloc(0, 1, 16'h0300, 16'h03FF, 1, "R2");
    cyc(8);
    #5 chk(reqValid == 1'b0, "R4", "depth cap", reqValid, 0);

    // LRU: buffer 0 least recently used in the read class
    expReq(16'h0400, 0, 0, "R2");
    expReq(16'h0401, 0, 0, "R2");
    doAlloc(0, 0, 16'h0400, 16'h0401, 0, "R2");
    cyc(6);
    peekId(0, 1, "R2");
    doFill(1, 16'hB300);
    expReq(16'h0304, 0, 1, "R7");
    doLookup(0, 16'h0300, 1, 16'hB300, "R7");
    cyc(3);
    peekId(0, 0, "R2");

    // class separation
    doFill(2, 16'hC200);
    doLookup(0, 16'h0200, 0, 0, "R7");
    doLookup(1, 16'h0200, 1, 16'hC200, "R7");
    cyc(3);

    // barrier
    doFill(1, 16'hB301);
    @(negedge clk);
    barrier = 1'b1;
    @(negedge clk);
    barrier = 1'b0;
    #5 chk(reqValid == 1'b0, "R9", "request after barrier", reqValid, 0);
    doLookup(0, 16'h0301, 0, 0, "R9");
    peekId(0, 0, "R9");

    // arbitration: two buffers ready together
    reqReady = 1'b0;
    expReq(16'h0500, 0, 0, "R10");
    expReq(16'h0501, 0, 0, "R10");
    expReq(16'h0600, 1, 2, "R10");
    expReq(16'h0601, 1, 2, "R10");
    doAlloc(0, 0, 16'h0500, 16'h05FF, 0, "R10");
    doAlloc(1, 0, 16'h0600, 16'h06FF, 2, "R10");
    @(negedge clk);
    reqReady = 1'b1;
    cyc(8);

    chk(expReqQ.size() == 0, "R10", "requests still expected", expReqQ.size(), 0);
    chk(expLookQ.size() == 0, "R7", "lookups still expected", expLookQ.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule